// File: doc/BRIEF.md
# Bit Test and Scan Unit

This execution unit handles the single-bit instructions of a 32-bit integer pipeline. It covers four test forms: plain test, test-and-set, test-and-reset and test-and-complement. It also covers two bit scans, one from the low end of the word and one from the high end. The issuing stage presents an operand, a bit index and an opcode, and pulses `start` for one cycle. One cycle later the unit raises `done` for one cycle. At that point the result word, carry flag and zero flag already hold the new values. These outputs are registers and keep their values until a later operation changes them.

Two enumerated states control the unit. `S_IDLE` waits for work. `S_REPLY` marks the cycle in which `done` is high. The transitions are:
- `T_ACCEPT` goes from `S_IDLE` to `S_REPLY` when `start` is high.
- `T_CHAIN` stays in `S_REPLY` when a new `start` arrives in that cycle.
- `T_RETIRE` goes from `S_REPLY` to `S_IDLE` when `start` is low.
- `T_HOLD` keeps `S_IDLE` when there is no `start`.

Test forms write the carry flag and scans write the zero flag. Neither kind touches the flag that belongs to the other.

Top module: `bts_unit`

## Requirements
- R1: When `start` is sampled high at a rising clock edge, `done` is high for the following cycle, with the registered outputs already updated. Without `start`, `done` stays low and the result, carry and zero outputs do not change.
- R2: Asynchronous active-low reset clears `result`, `cf`, `zf` and `done` to 0.
- R3: For the test forms (opcode 0 test, 1 set, 2 reset, 3 complement), `cf` takes the value the selected operand bit had before any change. The selected bit is `bit_index` modulo 32, that is, its low 5 bits.
- R4: Opcode 0 returns the operand unchanged in `result`.
- R5: Opcode 1 returns the operand with the selected bit forced to 1. Opcode 2 forces that bit to 0. Opcode 3 inverts that bit. All other bits pass through unchanged.
- R6: Opcode 4 (forward scan) returns the position of the lowest set bit of the operand, zero-extended to 32 bits.
- R7: Opcode 5 (reverse scan) returns the position of the highest set bit of the operand, zero-extended to 32 bits.
- R8: A scan of a nonzero operand sets `zf` to 1. A scan of a zero operand clears `zf` to 0 and leaves `result` at its previous value.
- R9: The test forms leave `zf` unchanged, and the scans leave `cf` unchanged.
- R10: Opcodes 6 and 7 are reserved. They still produce the `done` pulse but leave `result`, `cf` and `zf` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request strobe |
| op | input | 3 | Operation code (0..7) |
| operand | input | 32 | Source word |
| bit_index | input | 8 | Bit position, used modulo 32 |
| result | output | 32 | Registered result word |
| cf | output | 1 | Registered carry flag |
| zf | output | 1 | Registered zero flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest conditions to create are the ones where an output must keep an old value. Examples are a scan of zero after a nonzero result, a test form after a scan has set `zf`, and a reserved opcode. Each of these is only visible when the preceding operation has left a value that a wrong design would overwrite. The vector table is therefore ordered so that each flag-preserving or result-preserving step follows a step that leaves a distinctive value. Directed tests then cover back-to-back strobes through `T_CHAIN`, idle cycles and a reset issued mid-stream.

// File: rtl/bts_pkg.sv
package bts_pkg;
    localparam int WORD_W = 32;
    localparam int SEL_W  = $clog2(WORD_W);

    typedef enum logic [2:0] {
        OP_TEST   = 3'd0,
        OP_SET    = 3'd1,
        OP_CLR    = 3'd2,
        OP_FLIP   = 3'd3,
        OP_SCAN_F = 3'd4,
        OP_SCAN_R = 3'd5,
        OP_RSV6   = 3'd6,
        OP_RSV7   = 3'd7
    } bts_op_e;

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_REPLY = 1'b1
    } bts_state_e;
endpackage

// File: rtl/bts_bitmod.sv
module bts_bitmod
    import bts_pkg::*;
#(
    parameter int W = 32,
    localparam int SW = $clog2(W)
) (
    input  bts_op_e        op,
    input  logic [W-1:0]   src,
    input  logic [SW-1:0]  sel,
    output logic [W-1:0]   dst,
    output logic           old_bit
);
    logic [W-1:0] mask;

    always_comb begin
        mask    = {{(W-1){1'b0}}, 1'b1} << sel;
        old_bit = src[sel];
        unique case (op)
            OP_SET:  dst = src | mask;
            OP_CLR:  dst = src & ~mask;
            OP_FLIP: dst = src ^ mask;
            default: dst = src;
        endcase
    end
endmodule

// File: rtl/bts_scan.sv
module bts_scan #(
    parameter int W = 32,
    parameter bit FROM_TOP = 1'b0,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  src,
    output logic [SW-1:0] pos,
    output logic          found
);
    assign found = |src;

    generate
        if (FROM_TOP) begin : g_rev
            always_comb begin
                pos = '0;
                for (int i = 0; i < W; i++)
                    if (src[i]) pos = i[SW-1:0];
            end
        end else begin : g_fwd
            always_comb begin
                pos = '0;
                for (int i = W - 1; i >= 0; i--)
                    if (src[i]) pos = i[SW-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/bts_unit.sv
module bts_unit
    import bts_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int IDX_W = 8,
    localparam int SW   = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [W-1:0]     operand,
    input  logic [IDX_W-1:0] bit_index,
    output logic [W-1:0]     result,
    output logic             cf,
    output logic             zf,
    output logic             done
);
    bts_op_e    op_e;
    bts_state_e state_q, state_d;
    logic [SW-1:0] sel;
    logic [W-1:0]  mod_res;
    logic          mod_cf;
    logic [SW-1:0] fwd_pos, rev_pos;
    logic          fwd_hit, rev_hit;
    logic          is_test;

    assign op_e    = bts_op_e'(op);
    assign sel     = bit_index[SW-1:0];
    assign is_test = (op_e == OP_TEST) || (op_e == OP_SET) ||
                     (op_e == OP_CLR)  || (op_e == OP_FLIP);

    bts_bitmod #(.W(W)) u_mod (
        .op(op_e), .src(operand), .sel(sel), .dst(mod_res), .old_bit(mod_cf)
    );
    bts_scan #(.W(W), .FROM_TOP(1'b0)) u_fwd (
        .src(operand), .pos(fwd_pos), .found(fwd_hit)
    );
    bts_scan #(.W(W), .FROM_TOP(1'b1)) u_rev (
        .src(operand), .pos(rev_pos), .found(rev_hit)
    );

    // Next-state logic: T_ACCEPT, T_CHAIN, T_RETIRE, T_HOLD
    always_comb begin
        unique case (state_q)
            S_IDLE:  state_d = start ? S_REPLY : S_IDLE;
            S_REPLY: state_d = start ? S_REPLY : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    assign done = (state_q == S_REPLY);

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            cf     <= 1'b0;
            zf     <= 1'b0;
        end else if (start) begin
            unique case (op_e)
                OP_TEST, OP_SET, OP_CLR, OP_FLIP: begin
                    result <= mod_res;
                    cf     <= mod_cf;
                end
                OP_SCAN_F: begin
                    if (fwd_hit) result <= {{(W-SW){1'b0}}, fwd_pos};
                    zf <= fwd_hit;
                end
                OP_SCAN_R: begin
                    if (rev_hit) result <= {{(W-SW){1'b0}}, rev_pos};
                    zf <= rev_hit;
                end
                default: ;
            endcase
        end
    end

    a_r1_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (!done && $stable(result) && $stable(cf) && $stable(zf)));
    a_r3_carry_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && is_test) |=> cf == $past(operand[int'(bit_index) % W]));
    a_r4_plain_test: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_e == OP_TEST) |=> result == $past(operand));
    a_r8_zero_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (op_e == OP_SCAN_F || op_e == OP_SCAN_R) && operand == '0)
        |=> (!zf && $stable(result)));
    a_r9_zf_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && is_test) |=> $stable(zf));
    a_r9_cf_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (op_e == OP_SCAN_F || op_e == OP_SCAN_R)) |=> $stable(cf));
    a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (op_e == OP_RSV6 || op_e == OP_RSV7))
        |=> ($stable(result) && $stable(cf) && $stable(zf)));
endmodule

// File: tb/tb_bts_unit.sv
module tb_bts_unit;
    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] opnd;
        logic [7:0]  idx;
        logic [31:0] res;
        logic        cf;
        logic        zf;
    } vec_t;

    // Ordered: each step relies on state left by the one before.
    localparam vec_t VEC [15] = '{
        '{3'd0, 32'h0000_0008, 8'd3,  32'h0000_0008, 1'b1, 1'b0}, // R3 R4
        '{3'd1, 32'h0000_0000, 8'd31, 32'h8000_0000, 1'b0, 1'b0}, // R5 set
        '{3'd2, 32'hFFFF_FFFF, 8'd36, 32'hFFFF_FFEF, 1'b1, 1'b0}, // R5 clr, R3 modulo
        '{3'd3, 32'h1234_5678, 8'd0,  32'h1234_5679, 1'b0, 1'b0}, // R5 flip
        '{3'd4, 32'h0001_0100, 8'd9,  32'h0000_0008, 1'b0, 1'b1}, // R6
        '{3'd5, 32'h0001_0100, 8'd9,  32'h0000_0010, 1'b0, 1'b1}, // R7
        '{3'd0, 32'h8000_0000, 8'd31, 32'h8000_0000, 1'b1, 1'b1}, // R9 zf kept
        '{3'd4, 32'h0000_0000, 8'd0,  32'h8000_0000, 1'b1, 1'b0}, // R8 zero, R9 cf kept
        '{3'd5, 32'h8000_0001, 8'd0,  32'h0000_001F, 1'b1, 1'b1}, // R7
        '{3'd4, 32'h8000_0001, 8'd0,  32'h0000_0000, 1'b1, 1'b1}, // R6
        '{3'd3, 32'hFFFF_FFFF, 8'd63, 32'h7FFF_FFFF, 1'b1, 1'b1}, // R5 R3
        '{3'd5, 32'h0000_0000, 8'd0,  32'h7FFF_FFFF, 1'b1, 1'b0}, // R8 zero
        '{3'd6, 32'h0000_ABCD, 8'd2,  32'h7FFF_FFFF, 1'b1, 1'b0}, // R10
        '{3'd7, 32'h0000_0000, 8'd0,  32'h7FFF_FFFF, 1'b1, 1'b0}, // R10
        '{3'd2, 32'h0000_0000, 8'd5,  32'h0000_0000, 1'b0, 1'b0}  // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] operand = '0;
    logic [7:0]  bit_index = '0;
    logic [31:0] result;
    logic        cf, zf, done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bts_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .operand(operand), .bit_index(bit_index),
        .result(result), .cf(cf), .zf(zf), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] o, input logic [31:0] d, input logic [7:0] i);
        @(negedge clk);
        op = o; operand = d; bit_index = i; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R2: reset state
        chk("R2 result", result, 32'h0);
        chk("R2 cf", {31'b0, cf}, 32'h0);
        chk("R2 zf", {31'b0, zf}, 32'h0);
        chk("R2 done", {31'b0, done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle done", {31'b0, done}, 32'h0);

        for (int k = 0; k < 15; k++) begin
            issue(VEC[k].op, VEC[k].opnd, VEC[k].idx);
            chk($sformatf("R1 done v%0d", k), {31'b0, done}, 32'h1);
            chk($sformatf("R4-R8 result v%0d", k), result, VEC[k].res);
            chk($sformatf("R3/R9 cf v%0d", k), {31'b0, cf}, {31'b0, VEC[k].cf});
            chk($sformatf("R8/R9 zf v%0d", k), {31'b0, zf}, {31'b0, VEC[k].zf});
            @(negedge clk);
            chk($sformatf("R1 pulse end v%0d", k), {31'b0, done}, 32'h0);
        end

        // R1: idle cycles keep everything
        repeat (3) @(negedge clk);
        chk("R1 idle result", result, 32'h0);
        chk("R1 idle done", {31'b0, done}, 32'h0);

        // R1 back-to-back strobes (T_CHAIN)
        @(negedge clk);
        op = 3'd1; operand = 32'h0; bit_index = 8'd1; start = 1'b1;
        @(negedge clk);
        chk("R1 chain done a", {31'b0, done}, 32'h1);
        chk("R5 chain set", result, 32'h0000_0002);
        op = 3'd5; operand = 32'h0000_0002;
        @(negedge clk);
        start = 1'b0;
        chk("R1 chain done b", {31'b0, done}, 32'h1);
        chk("R7 chain scan", result, 32'h0000_0001);
        chk("R8 chain zf", {31'b0, zf}, 32'h1);
        @(negedge clk);
        chk("R1 chain end", {31'b0, done}, 32'h0);

        // R3 test of a clear bit with wide index, R9 zf held at 1
        issue(3'd0, 32'hFFFF_FFFE, 8'd224);
        chk("R3 wide index cf", {31'b0, cf}, 32'h0);
        chk("R9 zf held", {31'b0, zf}, 32'h1);

        // R2: reset mid-stream
        issue(3'd1, 32'h0, 8'd7);
        rst_n = 1'b0;
        #1;
        chk("R2 async result", result, 32'h0);
        chk("R2 async done", {31'b0, done}, 32'h0);
        chk("R2 async zf", {31'b0, zf}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule